// File: doc/BRIEF.md
# Snooping Write-Through Invalidate Cache Controller

This block is the private cache controller that sits between one processor and the shared bus of a small shared-memory multiprocessor. It keeps a direct-mapped array of one-word lines. Each line is either Valid or Invalid, and an absent line counts as Invalid. Memory is kept current because every processor store goes straight out on the bus. A store never brings a line into the cache. A store that hits refreshes the local copy.

Coherence comes from watching the bus. When another agent writes an address that this cache holds, the local line is dropped, and the next read of that address fetches the new value. Snooped reads are harmless and leave the lines alone. The controller recognises its own traffic on the snoop port by a requester ID and ignores it.

A bus transaction runs through three phases in order: the controller raises a request, waits for a grant, places a one-cycle command carrying address and ID, then waits for the data phase to complete. A read fill is abandoned and re-issued if a foreign write to the same address is snooped while the read is outstanding.

Top module: `wt_snoop_cache`

## Requirements
- R1: After reset every line is Invalid; `cpu_req_ready` is 1 and `bus_req`, `bus_cmd_valid` and `cpu_resp_valid` are 0.
- R2: A read of an address whose line is Invalid or holds another tag raises a bus request. After the grant the controller issues one command cycle with `bus_cmd_write`=0, the read address and `bus_cmd_id` equal to `MY_ID`. On data completion the line becomes Valid and the bus data is returned on the response.
- R3: A read that hits returns the cached word with `cpu_resp_valid` in the cycle after acceptance. It causes no bus request, and `cpu_req_ready` stays 1.
- R4: Every processor write, hit or miss, issues exactly one bus command with `bus_cmd_write`=1 and the write address and data. The write is acknowledged with `cpu_resp_valid` after the data phase completes.
- R5: A write that misses does not allocate, so a later read of that address misses and goes to the bus.
- R6: A write that hits updates the local copy, so a later read hits and returns the written data with no bus traffic.
- R7: A snooped write (`snp_valid`=1, `snp_write`=1) whose `snp_id` differs from `MY_ID` and whose address matches a Valid line makes that line Invalid.
- R8: A snooped read (`snp_write`=0), and any snooped transaction whose `snp_id` equals `MY_ID`, leaves every line unchanged.
- R9: If a foreign snooped write to the address of an outstanding read arrives before or in the cycle of its data completion, that data is discarded. A new bus read is issued, and the processor receives the data of the second transaction.
- R10: `cpu_req_ready` is 0 from the cycle the bus request is raised until the data phase completes. The command cycle follows a granted request, and request and command are never active together.
- R11: The line index is the low log2(LINES) address bits (bits 3:0 by default) and the tag is the remaining upper bits. Two addresses with the same index and different tags evict each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_write | input | 1 | 1 = store, 0 = load |
| cpu_req_addr | input | ADDR_W | Word address of the request |
| cpu_req_wdata | input | DATA_W | Store data |
| cpu_req_ready | output | 1 | Controller can accept a request |
| cpu_resp_valid | output | 1 | One-cycle completion pulse |
| cpu_resp_rdata | output | DATA_W | Load data, valid with the response |
| bus_req | output | 1 | Arbitration request |
| bus_gnt | input | 1 | Arbitration grant |
| bus_cmd_valid | output | 1 | Command/address phase |
| bus_cmd_write | output | 1 | 1 = bus write, 0 = bus read |
| bus_cmd_addr | output | ADDR_W | Command address |
| bus_cmd_wdata | output | DATA_W | Bus write data |
| bus_cmd_id | output | ID_W | Requester ID (MY_ID) |
| bus_done | input | 1 | Data phase complete |
| bus_rdata | input | DATA_W | Read data, valid with bus_done |
| snp_valid | input | 1 | Snooped transaction present |
| snp_write | input | 1 | Snooped transaction is a write |
| snp_addr | input | ADDR_W | Snooped address |
| snp_id | input | ID_W | Requester ID of the snooped transaction |

## Verification
The assertions check the bus handshake rules on every cycle. They confirm that the processor port stalls while a request is raised, that a command follows a grant, and that request and command are exclusive. They also check that stores always reach the bus, that a read hit responds in one cycle without a request, and that a read miss requests the bus. Only the bench's scenarios can show that data stays coherent. That covers several cases: a store miss leaves no line behind, a store hit refreshes the copy, foreign snooped writes invalidate while snooped reads and self-echoes do not, conflicting indices evict, and an invalidation racing an outstanding fill forces a second bus read with fresh data.

// File: rtl/wtc_pkg.sv
package wtc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ARB  = 2'd1,
        ST_CMD  = 2'd2,
        ST_DATA = 2'd3
    } ctl_st_e;

endpackage

// File: rtl/wtc_array.sv
module wtc_array #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int LINES  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic              lk_hit,
    output logic [DATA_W-1:0] lk_data,
    input  logic              fill_en,
    input  logic              upd_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              snp_inv_en,
    input  logic [ADDR_W-1:0] snp_addr
);
    localparam int IW = $clog2(LINES);
    localparam int TW = ADDR_W - IW;

    typedef struct packed {
        logic              valid;
        logic [TW-1:0]     tag;
        logic [DATA_W-1:0] data;
    } line_t;

    line_t line_q [LINES];
    line_t line_d [LINES];

    logic [IW-1:0] lk_idx, wr_idx, snp_idx;
    logic [TW-1:0] lk_tag, wr_tag, snp_tag;
    logic [LINES-1:0] inv_line;

    assign lk_idx  = lk_addr[IW-1:0];
    assign lk_tag  = lk_addr[ADDR_W-1:IW];
    assign wr_idx  = wr_addr[IW-1:0];
    assign wr_tag  = wr_addr[ADDR_W-1:IW];
    assign snp_idx = snp_addr[IW-1:0];
    assign snp_tag = snp_addr[ADDR_W-1:IW];

    assign lk_hit  = line_q[lk_idx].valid && (line_q[lk_idx].tag == lk_tag);
    assign lk_data = line_q[lk_idx].data;

    // per-line snoop match
    for (genvar g = 0; g < LINES; g++) begin : g_snp
        assign inv_line[g] = snp_inv_en && (snp_idx == IW'(g)) &&
                             line_q[g].valid && (line_q[g].tag == snp_tag);
    end

    always_comb begin
        for (int i = 0; i < LINES; i++) begin
            line_d[i] = line_q[i];
            if (inv_line[i]) begin
                line_d[i].valid = 1'b0;
            end
        end
        if (upd_en) begin
            line_d[wr_idx].data = wr_data;
        end
        if (fill_en) begin
            line_d[wr_idx].valid = 1'b1;
            line_d[wr_idx].tag   = wr_tag;
            line_d[wr_idx].data  = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < LINES; i++) begin
                line_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < LINES; i++) begin
                line_q[i] <= line_d[i];
            end
        end
    end

endmodule

// File: rtl/wtc_ctrl.sv
module wtc_ctrl
    import wtc_pkg::*;
#(
    parameter int              ADDR_W = 32,
    parameter int              DATA_W = 32,
    parameter int              ID_W   = 2,
    parameter logic [ID_W-1:0] MY_ID  = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req_valid,
    input  logic              cpu_req_write,
    input  logic [ADDR_W-1:0] cpu_req_addr,
    input  logic [DATA_W-1:0] cpu_req_wdata,
    output logic              cpu_req_ready,
    output logic              cpu_resp_valid,
    output logic [DATA_W-1:0] cpu_resp_rdata,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic              bus_cmd_valid,
    output logic              bus_cmd_write,
    output logic [ADDR_W-1:0] bus_cmd_addr,
    output logic [DATA_W-1:0] bus_cmd_wdata,
    input  logic              bus_done,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              snp_valid,
    input  logic              snp_write,
    input  logic [ADDR_W-1:0] snp_addr,
    input  logic [ID_W-1:0]   snp_id,
    output logic [ADDR_W-1:0] lk_addr,
    input  logic              lk_hit,
    input  logic [DATA_W-1:0] lk_data,
    output logic              fill_en,
    output logic              upd_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              snp_inv_en
);
    typedef struct packed {
        ctl_st_e           st;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic              write;
        logic              kill;
        logic              resp_valid;
        logic [DATA_W-1:0] rdata;
    } ctl_t;

    ctl_t q, d;
    logic kill_now, kill_any;

    // foreign writes only; own traffic echoed on the snoop port is ignored
    assign snp_inv_en = snp_valid && snp_write && (snp_id != MY_ID);
    assign kill_now   = snp_inv_en && (q.st != ST_IDLE) && (snp_addr == q.addr);
    assign kill_any   = q.kill || kill_now;

    assign lk_addr = (q.st == ST_IDLE) ? cpu_req_addr : q.addr;
    assign wr_addr = q.addr;
    assign wr_data = q.write ? q.wdata : bus_rdata;

    always_comb begin
        d            = q;
        d.resp_valid = 1'b0;
        fill_en      = 1'b0;
        upd_en       = 1'b0;
        if (q.st != ST_IDLE && kill_now) begin
            d.kill = 1'b1;
        end
        unique case (q.st)
            ST_IDLE: begin
                if (cpu_req_valid) begin
                    d.addr  = cpu_req_addr;
                    d.wdata = cpu_req_wdata;
                    d.write = cpu_req_write;
                    d.kill  = 1'b0;
                    if (cpu_req_write) begin
                        d.st = ST_ARB;
                    end else if (lk_hit) begin
                        d.resp_valid = 1'b1;
                        d.rdata      = lk_data;
                    end else begin
                        d.st = ST_ARB;
                    end
                end
            end
            ST_ARB: begin
                if (bus_gnt) begin
                    d.st = ST_CMD;
                end
            end
            ST_CMD: begin
                d.st = ST_DATA;
            end
            ST_DATA: begin
                if (bus_done) begin
                    if (q.write) begin
                        upd_en       = lk_hit && !kill_any;
                        d.resp_valid = 1'b1;
                        d.st         = ST_IDLE;
                    end else if (kill_any) begin
                        d.kill = 1'b0;
                        d.st   = ST_ARB;
                    end else begin
                        fill_en      = 1'b1;
                        d.resp_valid = 1'b1;
                        d.rdata      = bus_rdata;
                        d.st         = ST_IDLE;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign cpu_req_ready  = (q.st == ST_IDLE);
    assign cpu_resp_valid = q.resp_valid;
    assign cpu_resp_rdata = q.rdata;
    assign bus_req        = (q.st == ST_ARB);
    assign bus_cmd_valid  = (q.st == ST_CMD);
    assign bus_cmd_write  = q.write;
    assign bus_cmd_addr   = q.addr;
    assign bus_cmd_wdata  = q.wdata;

endmodule

// File: rtl/wt_snoop_cache.sv
module wt_snoop_cache #(
    parameter int              ADDR_W = 32,
    parameter int              DATA_W = 32,
    parameter int              LINES  = 16,
    parameter int              ID_W   = 2,
    parameter logic [ID_W-1:0] MY_ID  = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req_valid,
    input  logic              cpu_req_write,
    input  logic [ADDR_W-1:0] cpu_req_addr,
    input  logic [DATA_W-1:0] cpu_req_wdata,
    output logic              cpu_req_ready,
    output logic              cpu_resp_valid,
    output logic [DATA_W-1:0] cpu_resp_rdata,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic              bus_cmd_valid,
    output logic              bus_cmd_write,
    output logic [ADDR_W-1:0] bus_cmd_addr,
    output logic [DATA_W-1:0] bus_cmd_wdata,
    output logic [ID_W-1:0]   bus_cmd_id,
    input  logic              bus_done,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              snp_valid,
    input  logic              snp_write,
    input  logic [ADDR_W-1:0] snp_addr,
    input  logic [ID_W-1:0]   snp_id
);
    logic [ADDR_W-1:0] lk_addr, wr_addr;
    logic [DATA_W-1:0] lk_data, wr_data;
    logic              lk_hit, fill_en, upd_en, snp_inv_en;

    assign bus_cmd_id = MY_ID;

    wtc_ctrl #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ID_W(ID_W), .MY_ID(MY_ID)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cpu_req_valid(cpu_req_valid), .cpu_req_write(cpu_req_write),
        .cpu_req_addr(cpu_req_addr), .cpu_req_wdata(cpu_req_wdata),
        .cpu_req_ready(cpu_req_ready), .cpu_resp_valid(cpu_resp_valid),
        .cpu_resp_rdata(cpu_resp_rdata),
        .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_cmd_valid(bus_cmd_valid),
        .bus_cmd_write(bus_cmd_write), .bus_cmd_addr(bus_cmd_addr),
        .bus_cmd_wdata(bus_cmd_wdata), .bus_done(bus_done), .bus_rdata(bus_rdata),
        .snp_valid(snp_valid), .snp_write(snp_write), .snp_addr(snp_addr),
        .snp_id(snp_id),
        .lk_addr(lk_addr), .lk_hit(lk_hit), .lk_data(lk_data),
        .fill_en(fill_en), .upd_en(upd_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .snp_inv_en(snp_inv_en)
    );

    wtc_array #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINES(LINES)
    ) u_array (
        .clk(clk), .rst_n(rst_n),
        .lk_addr(lk_addr), .lk_hit(lk_hit), .lk_data(lk_data),
        .fill_en(fill_en), .upd_en(upd_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .snp_inv_en(snp_inv_en), .snp_addr(snp_addr)
    );

endmodule

// File: rtl/wtc_checker.sv
module wtc_checker (
    input logic clk,
    input logic rst_n,
    input logic cpu_req_valid,
    input logic cpu_req_write,
    input logic cpu_req_ready,
    input logic cpu_resp_valid,
    input logic bus_req,
    input logic bus_gnt,
    input logic bus_cmd_valid,
    input logic lk_hit
);
    logic accept;
    assign accept = cpu_req_valid && cpu_req_ready;

    AST_STALL_WHILE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> !cpu_req_ready); // R10

    AST_CMD_AFTER_GNT: assert property (@(posedge clk) disable iff (!rst_n)
        bus_cmd_valid |-> $past(bus_req && bus_gnt)); // R10

    AST_PHASE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({bus_req, bus_cmd_valid})); // R10

    AST_STORE_TO_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        accept && cpu_req_write |=> bus_req); // R4

    AST_HIT_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
        accept && !cpu_req_write && lk_hit |=> cpu_resp_valid && !bus_req && cpu_req_ready); // R3

    AST_MISS_TO_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        accept && !cpu_req_write && !lk_hit |=> bus_req && !cpu_resp_valid); // R2

endmodule

bind wt_snoop_cache wtc_checker u_chk (
    .clk(clk), .rst_n(rst_n),
    .cpu_req_valid(cpu_req_valid), .cpu_req_write(cpu_req_write),
    .cpu_req_ready(cpu_req_ready), .cpu_resp_valid(cpu_resp_valid),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_cmd_valid(bus_cmd_valid),
    .lk_hit(lk_hit)
);

// File: tb/wt_snoop_cache_test.sv
module wt_snoop_cache_test;
    localparam int CLK_P = 10;
    localparam logic [1:0] MYID = 2'd1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_P/2) clk = ~clk;

    logic        cpu_req_valid = 0, cpu_req_write = 0;
    logic [31:0] cpu_req_addr = 0, cpu_req_wdata = 0;
    logic        cpu_req_ready, cpu_resp_valid;
    logic [31:0] cpu_resp_rdata;
    logic        bus_req, bus_cmd_valid, bus_cmd_write;
    logic        bus_gnt = 0, bus_done = 0;
    logic [31:0] bus_cmd_addr, bus_cmd_wdata;
    logic [31:0] bus_rdata = 0;
    logic [1:0]  bus_cmd_id;
    logic        snp_valid = 0, snp_write = 0;
    logic [31:0] snp_addr = 0;
    logic [1:0]  snp_id = 0;

    wt_snoop_cache #(.MY_ID(MYID)) uut (
        .clk(clk), .rst_n(rst_n),
        .cpu_req_valid(cpu_req_valid), .cpu_req_write(cpu_req_write),
        .cpu_req_addr(cpu_req_addr), .cpu_req_wdata(cpu_req_wdata),
        .cpu_req_ready(cpu_req_ready), .cpu_resp_valid(cpu_resp_valid),
        .cpu_resp_rdata(cpu_resp_rdata),
        .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_cmd_valid(bus_cmd_valid),
        .bus_cmd_write(bus_cmd_write), .bus_cmd_addr(bus_cmd_addr),
        .bus_cmd_wdata(bus_cmd_wdata), .bus_cmd_id(bus_cmd_id),
        .bus_done(bus_done), .bus_rdata(bus_rdata),
        .snp_valid(snp_valid), .snp_write(snp_write), .snp_addr(snp_addr),
        .snp_id(snp_id)
    );

    int  total = 0, bad = 0;
    bit  finished = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // memory and reference cache model
    logic [31:0] mem [logic [31:0]];
    bit          rv [16];
    logic [27:0] rt [16];

    function automatic logic [31:0] mrd(input logic [31:0] a);
        return mem.exists(a) ? mem[a] : (a ^ 32'hA5A5_0000);
    endfunction

    function automatic bit ref_hit(input logic [31:0] a);
        return rv[a[3:0]] && (rt[a[3:0]] == a[31:4]);
    endfunction

    // bus agent: arbiter + memory
    int nrd = 0, nwr = 0;
    logic [31:0] last_wa = 0, last_wd = 0;

    initial begin
        int bs = 0, cnt = 0;
        logic [31:0] lat = 0;
        forever begin
            @(negedge clk);
            if (!rst_n) begin
                bs = 0; bus_gnt = 0; bus_done = 0;
            end else begin
                if (bus_req) chk(!cpu_req_ready, "R10 ready during request", 32'(cpu_req_ready), 0);
                case (bs)
                    0: if (bus_req) begin cnt = $urandom_range(0, 2); bs = 1; end
                    1: if (cnt == 0) begin bus_gnt = 1; bs = 2; end else cnt--;
                    2: begin
                        bus_gnt = 0;
                        chk(bus_cmd_valid && !bus_req, "R10 command after grant", 32'(bus_cmd_valid), 1);
                        chk(bus_cmd_id == MYID, "R2 command id", 32'(bus_cmd_id), 32'(MYID));
                        if (bus_cmd_write) begin
                            mem[bus_cmd_addr] = bus_cmd_wdata;
                            last_wa = bus_cmd_addr; last_wd = bus_cmd_wdata;
                            nwr++;
                            lat = 32'hDEAD_BEEF;
                        end else begin
                            lat = mrd(bus_cmd_addr);
                            nrd++;
                        end
                        cnt = $urandom_range(0, 3);
                        bs = 3;
                    end
                    3: if (cnt == 0) begin bus_done = 1; bus_rdata = lat; bs = 4; end else cnt--;
                    default: begin bus_done = 0; bs = 0; end
                endcase
            end
        end
    end

    task automatic cpu_op(input bit wr, input logic [31:0] a, input logic [31:0] wd,
                          output logic [31:0] rd, output int lat, output bit rdy);
        @(negedge clk);
        cpu_req_valid = 1; cpu_req_write = wr; cpu_req_addr = a; cpu_req_wdata = wd;
        lat = 0;
        forever begin
            @(negedge clk);
            if (lat == 0) cpu_req_valid = 0;
            lat++;
            if (cpu_resp_valid || lat > 200) break;
        end
        rd = cpu_resp_rdata; rdy = cpu_req_ready;
    endtask

    task automatic rd_check(input logic [31:0] a, input string req);
        logic [31:0] d; int lat; bit rdy; int n0; bit h;
        n0 = nrd; h = ref_hit(a);
        cpu_op(0, a, 0, d, lat, rdy);
        chk(d == mrd(a), {req, " read data"}, d, mrd(a));
        chk((nrd - n0) == (h ? 0 : 1), {req, " bus reads"}, 32'(nrd - n0), h ? 0 : 1);
        if (h) chk(lat == 1 && rdy, {req, " R3 hit latency"}, 32'(lat), 1);
        rv[a[3:0]] = 1; rt[a[3:0]] = a[31:4];
    endtask

    task automatic wr_check(input logic [31:0] a, input logic [31:0] wd, input string req);
        logic [31:0] d; int lat; bit rdy; int n0;
        n0 = nwr;
        cpu_op(1, a, wd, d, lat, rdy);
        chk((nwr - n0) == 1, {req, " R4 bus writes"}, 32'(nwr - n0), 1);
        chk(last_wa == a && last_wd == wd, {req, " R4 write addr/data"}, last_wd, wd);
    endtask

    task automatic snoop(input logic [31:0] a, input logic [31:0] v, input bit wr, input logic [1:0] id);
        @(negedge clk);
        snp_valid = 1; snp_write = wr; snp_addr = a; snp_id = id;
        if (wr && id != MYID) begin
            mem[a] = v;
            if (ref_hit(a)) rv[a[3:0]] = 0;
        end
        @(negedge clk);
        snp_valid = 0;
    endtask

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < 16; i++) begin rv[i] = 0; rt[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(cpu_req_ready == 1, "R1 ready after reset", 32'(cpu_req_ready), 1);
        chk(!bus_req && !bus_cmd_valid, "R1 bus idle after reset", 32'({bus_req, bus_cmd_valid}), 0);
        chk(!cpu_resp_valid, "R1 no response after reset", 32'(cpu_resp_valid), 0);

        rd_check(32'h10, "R1 R2 cold miss");
        rd_check(32'h10, "R3 hit");
        wr_check(32'h10, 32'h1111_0001, "R6 write hit");
        rd_check(32'h10, "R6 read after write hit");
        wr_check(32'h23, 32'h2222_0002, "R5 write miss");
        rd_check(32'h23, "R5 read after write miss");
        snoop(32'h10, 32'h3333_0003, 1, 2'd2);
        rd_check(32'h10, "R7 read after foreign snoop write");
        snoop(32'h23, 0, 0, 2'd0);
        rd_check(32'h23, "R8 read after snooped read");
        snoop(32'h23, mrd(32'h23), 1, MYID);
        rd_check(32'h23, "R8 read after own-id snoop");
        rd_check(32'h05, "R11 first");
        rd_check(32'h15, "R11 conflict");
        rd_check(32'h05, "R11 evicted");

        // R9: invalidation racing an outstanding fill
        begin
            logic [31:0] d; int lat; bit rdy; int n0;
            n0 = nrd;
            fork
                cpu_op(0, 32'h40, 0, d, lat, rdy);
                begin
                    do @(negedge clk); while (!bus_cmd_valid);
                    snoop(32'h40, 32'h4444_0004, 1, 2'd3);
                end
            join
            chk((nrd - n0) == 2, "R9 re-issued bus read", 32'(nrd - n0), 2);
            chk(d == 32'h4444_0004, "R9 fresh data", d, 32'h4444_0004);
            rv[0] = 1; rt[0] = 28'h4;
            rd_check(32'h40, "R9 line valid after refill");
        end

        for (int it = 0; it < 400; it++) begin
            int sel;
            logic [31:0] a;
            sel = $urandom_range(0, 99);
            a = 32'($urandom_range(0, 47));
            if (sel < 50) rd_check(a, "R2 R3 random read");
            else if (sel < 78) wr_check(a, $urandom, "R5 R6 random write");
            else begin
                logic [1:0] id;
                bit w;
                id = 2'($urandom_range(0, 3));
                w = 1'($urandom_range(0, 1));
                if (id == MYID) snoop(a, mrd(a), w, id);
                else snoop(a, $urandom, w, id);
                rd_check(a, "R7 R8 random snoop");
            end
        end

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL R10 watchdog act=%0d exp=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule